// File: doc/BRIEF.md
# Predicated Scalar-to-Vector Broadcast Unit

This block executes one instruction form: a masked broadcast of a 64-bit scalar into the elements of a vector register. It takes a 32-bit instruction word and checks it against one fixed encoding. From the word it extracts an element size, a predicate register index, a scalar source index and a destination vector index. It returns those indices at once so that the surrounding register files can supply the operands in the same cycle. The unit stores no registers of its own.

The scalar operand comes from the general register read port, or from the stack pointer when the source index is 31. The low element-width bits of that operand go into every element whose governing predicate bit is set. Every other element keeps its old destination value. The predicate has one bit per vector byte. An element is governed by the predicate bit that belongs to its lowest byte.

The result, the destination index and the flags are registered. They appear one cycle after a valid input. A word that does not match the encoding raises an illegal-instruction flag and writes nothing.

Top module: `pred_bcast`

## Requirements
- R1: A word is legal only when bits [31:24] equal 8'b00000101 and bits [21:13] equal 9'b101000101. For any other valid word, `res_illegal` is 1, `res_we` is 0 and `res_vec` equals the old vector.
- R2: Each output is registered. When `in_valid` is high in a cycle, `res_valid` is high in the next cycle and reflects that word. When `in_valid` is low in a cycle, `res_valid` is low in the next cycle.
- R3: Bits [23:22] give the element width: 00 is 8 bits, 01 is 16, 10 is 32 and 11 is 64. The vector therefore holds VLEN divided by that width elements.
- R4: Element e is active exactly when predicate bit e*(width/8) is 1. The other predicate bits have no effect.
- R5: Each active element receives bits [width-1:0] of the scalar operand.
- R6: Each inactive element in `res_vec` equals the same element of `old_vec`.
- R7: `rs_idx` equals bits [9:5] combinationally. Index 31 selects `sp_data` as the operand. Indices 0 to 30 select `gpr_data`.
- R8: `pg_idx` equals bits [12:10] and `vd_idx` equals bits [4:0], both combinationally. `res_vd` is the registered copy of bits [4:0].
- R9: For a legal word with no active element, `res_we` is 0 and `res_vec` equals `old_vec`. For a legal word with at least one active element, `res_we` is 1.
- R10: After reset, `res_valid`, `res_illegal` and `res_we` are 0, `res_vd` is 0 and `res_vec` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Instruction word and operands are valid this cycle |
| in_insn | input | 32 | Instruction word |
| rs_idx | output | 5 | Scalar source index for the general register read port |
| pg_idx | output | 3 | Governing predicate register index |
| vd_idx | output | 5 | Destination vector index, used to read the old vector |
| gpr_data | input | 64 | General register value for `rs_idx` |
| sp_data | input | 64 | Stack pointer value |
| pred_val | input | VLEN/8 | Governing predicate, one bit per vector byte |
| old_vec | input | VLEN | Current destination vector contents |
| res_valid | output | 1 | Registered result is present |
| res_illegal | output | 1 | The word did not match the encoding |
| res_we | output | 1 | Write `res_vec` to vector register `res_vd` |
| res_vd | output | 5 | Destination vector index of the result |
| res_vec | output | VLEN | Merged result vector |

## Verification
Random legal words cover all four element sizes with random predicates, operands and old vectors. These runs separate correct element slicing from byte-granular or misaligned merging. Predicates that set only the non-lead bits of each element must leave the destination unchanged and `res_we` low, which shows that the lead bit alone governs an element. All-ones and all-zero predicates mark the two ends of the merge. Source indices 30 and 31, given different scalar and stack-pointer values, expose a wrong operand choice. Words with a single bit flipped in either fixed-opcode field must be flagged illegal.

// File: rtl/pbc_pkg.sv
package pbc_pkg;
   typedef enum logic [1:0] {
      ESZ_B8  = 2'b00,
      ESZ_B16 = 2'b01,
      ESZ_B32 = 2'b10,
      ESZ_B64 = 2'b11
   } esz_e;

   localparam logic [7:0] OPC_TOP = 8'b00000101;
   localparam logic [8:0] OPC_MID = 9'b101000101;
   localparam logic [4:0] SP_SEL  = 5'd31;

   typedef struct packed {
      logic       legal;
      esz_e       esz;
      logic [2:0] pg;
      logic [4:0] rs;
      logic [4:0] vd;
      logic       use_sp;
   } dec_t;
endpackage

// File: rtl/pbc_decode.sv
module pbc_decode
   import pbc_pkg::*;
(
   input  logic [31:0] insn,
   output dec_t        dec
);
   always_comb begin
      dec.legal  = (insn[31:24] == OPC_TOP) && (insn[21:13] == OPC_MID);
      dec.esz    = esz_e'(insn[23:22]);
      dec.pg     = insn[12:10];
      dec.rs     = insn[9:5];
      dec.vd     = insn[4:0];
      dec.use_sp = (insn[9:5] == SP_SEL);
   end
endmodule

// File: rtl/pbc_lane.sv
module pbc_lane
   import pbc_pkg::*;
#(
   parameter int LANE = 0,
   parameter int PW   = 32
) (
   input  esz_e          esz,
   input  logic [PW-1:0] pred,
   input  logic [63:0]   op,
   input  logic [7:0]    old_b,
   output logic [7:0]    new_b,
   output logic          act
);
   // lead predicate bit of the element that owns this byte, per size
   localparam int LEAD1 = LANE - (LANE % 2);
   localparam int LEAD2 = LANE - (LANE % 4);
   localparam int LEAD3 = LANE - (LANE % 8);
   // byte position inside the element, picks the scalar byte
   localparam int OFS1  = LANE % 2;
   localparam int OFS2  = LANE % 4;
   localparam int OFS3  = LANE % 8;

   if (LANE >= PW) begin : g_bad_lane
      $error("pbc_lane: LANE outside predicate width");
   end

   logic [7:0] src_b;

   always_comb begin
      unique case (esz)
         ESZ_B8:  begin act = pred[LANE];  src_b = op[7:0];           end
         ESZ_B16: begin act = pred[LEAD1]; src_b = op[8*OFS1 +: 8];   end
         ESZ_B32: begin act = pred[LEAD2]; src_b = op[8*OFS2 +: 8];   end
         default: begin act = pred[LEAD3]; src_b = op[8*OFS3 +: 8];   end
      endcase
      new_b = act ? src_b : old_b;
   end
endmodule

// File: rtl/pred_bcast.sv
module pred_bcast
   import pbc_pkg::*;
#(
   parameter int VLEN = 256
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [31:0]       in_insn,
   output logic [4:0]        rs_idx,
   output logic [2:0]        pg_idx,
   output logic [4:0]        vd_idx,
   input  logic [63:0]       gpr_data,
   input  logic [63:0]       sp_data,
   input  logic [VLEN/8-1:0] pred_val,
   input  logic [VLEN-1:0]   old_vec,
   output logic              res_valid,
   output logic              res_illegal,
   output logic              res_we,
   output logic [4:0]        res_vd,
   output logic [VLEN-1:0]   res_vec
);
   localparam int NBYTES = VLEN / 8;

   if ((VLEN % 128) != 0 || VLEN < 128) begin : g_bad_vlen
      $error("pred_bcast: VLEN must be a non-zero multiple of 128");
   end

   dec_t              dec;
   logic [63:0]       operand;
   logic [NBYTES-1:0] lane_act;
   logic [VLEN-1:0]   merged;
   logic              any_act;

   pbc_decode u_dec (.insn(in_insn), .dec(dec));

   assign rs_idx  = dec.rs;
   assign pg_idx  = dec.pg;
   assign vd_idx  = dec.vd;
   assign operand = dec.use_sp ? sp_data : gpr_data;

   for (genvar b = 0; b < NBYTES; b++) begin : g_lane
      pbc_lane #(.LANE(b), .PW(NBYTES)) u_lane (
         .esz   (dec.esz),
         .pred  (pred_val),
         .op    (operand),
         .old_b (old_vec[8*b +: 8]),
         .new_b (merged[8*b +: 8]),
         .act   (lane_act[b])
      );
   end

   assign any_act = |lane_act;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid   <= 1'b0;
         res_illegal <= 1'b0;
         res_we      <= 1'b0;
         res_vd      <= '0;
         res_vec     <= '0;
      end else begin
         res_valid <= in_valid;
         if (in_valid) begin
            res_illegal <= !dec.legal;
            res_we      <= dec.legal && any_act;
            res_vd      <= dec.vd;
            res_vec     <= dec.legal ? merged : old_vec;
         end else begin
            res_illegal <= 1'b0;
            res_we      <= 1'b0;
         end
      end
   end

   p_we_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
      res_we |-> !res_illegal);
   p_valid_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> res_valid);
   p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!res_valid && !res_we && !res_illegal));
   p_noact_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !any_act) |=> (!res_we && res_vec == $past(old_vec)));
   p_illegal_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !dec.legal) |=> (res_illegal && res_vec == $past(old_vec)));
endmodule

// File: tb/tb_pred_bcast.sv
module tb_pred_bcast;
   localparam int VLEN = 256;
   localparam int PW   = VLEN / 8;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            in_valid = 1'b0;
   logic [31:0]     in_insn = '0;
   logic [4:0]      rs_idx, vd_idx, res_vd;
   logic [2:0]      pg_idx;
   logic [63:0]     gpr_data = '0, sp_data = '0;
   logic [PW-1:0]   pred_val = '0;
   logic [VLEN-1:0] old_vec = '0, res_vec;
   logic            res_valid, res_illegal, res_we;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   pred_bcast #(.VLEN(VLEN)) dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_insn(in_insn),
      .rs_idx(rs_idx), .pg_idx(pg_idx), .vd_idx(vd_idx),
      .gpr_data(gpr_data), .sp_data(sp_data), .pred_val(pred_val),
      .old_vec(old_vec), .res_valid(res_valid), .res_illegal(res_illegal),
      .res_we(res_we), .res_vd(res_vd), .res_vec(res_vec)
   );

   task automatic chk(input string req, input logic [VLEN-1:0] act,
                      input logic [VLEN-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] mk(input logic [1:0] sz, input logic [2:0] pg,
                                      input logic [4:0] rn, input logic [4:0] vd);
      return {8'b00000101, sz, 9'b101000101, pg, rn, vd};
   endfunction

   function automatic bit is_legal(input logic [31:0] w);
      return (w[31:24] == 8'b00000101) && (w[21:13] == 9'b101000101);
   endfunction

   function automatic logic [VLEN-1:0] ref_vec(input logic [31:0] w,
         input logic [PW-1:0] p, input logic [VLEN-1:0] old,
         input logic [63:0] g, input logic [63:0] s);
      logic [VLEN-1:0] r = old;
      logic [63:0] op = (w[9:5] == 5'd31) ? s : g;
      int esz = 8 << w[23:22];
      if (!is_legal(w)) return old;
      for (int e = 0; e < VLEN / esz; e++)
         if (p[e * (esz / 8)])
            for (int i = 0; i < esz; i++) r[e * esz + i] = op[i];
      return r;
   endfunction

   function automatic bit ref_we(input logic [31:0] w, input logic [PW-1:0] p);
      int esz = 8 << w[23:22];
      bit any = 1'b0;
      for (int e = 0; e < VLEN / esz; e++) if (p[e * (esz / 8)]) any = 1'b1;
      return is_legal(w) && any;
   endfunction

   task automatic apply(input logic [31:0] w, input logic [PW-1:0] p,
                        input logic [VLEN-1:0] old, input logic [63:0] g,
                        input logic [63:0] s);
      @(negedge clk);
      chk("R2 idle", VLEN'(res_valid), '0);
      in_valid = 1'b1; in_insn = w; pred_val = p; old_vec = old;
      gpr_data = g; sp_data = s;
      #1;
      chk("R7 rs_idx", VLEN'(rs_idx), VLEN'(w[9:5]));
      chk("R8 pg_idx", VLEN'(pg_idx), VLEN'(w[12:10]));
      chk("R8 vd_idx", VLEN'(vd_idx), VLEN'(w[4:0]));
      @(negedge clk);
      chk("R2 valid", VLEN'(res_valid), VLEN'(1));
      chk("R1 illegal", VLEN'(res_illegal), VLEN'(!is_legal(w)));
      chk("R9 we", VLEN'(res_we), VLEN'(ref_we(w, p)));
      chk("R5 R6 vec", res_vec, ref_vec(w, p, old, g, s));
      chk("R8 res_vd", VLEN'(res_vd), VLEN'(w[4:0]));
      in_valid = 1'b0;
   endtask

   function automatic logic [VLEN-1:0] rnd_vec();
      logic [VLEN-1:0] v;
      for (int k = 0; k < VLEN / 32; k++) v[32*k +: 32] = $urandom;
      return v;
   endfunction

   initial begin
      logic [VLEN-1:0] ov;
      logic [63:0] g, s;
      logic [31:0] w;
      void'($urandom(32'd7741));
      #12;
      chk("R10 res_valid", VLEN'(res_valid), '0);
      chk("R10 res_we", VLEN'(res_we), '0);
      chk("R10 res_vec", res_vec, '0);
      rst_n = 1'b1;
      g = 64'h1122_3344_5566_7788;
      s = 64'hA0B1_C2D3_E4F5_0617;
      // R3 R5: every size, all lanes active
      for (int sz = 0; sz < 4; sz++)
         apply(mk(2'(sz), 3'd2, 5'd4, 5'd9), '1, rnd_vec(), g, s);
      // R9: no predicate bit set
      for (int sz = 0; sz < 4; sz++)
         apply(mk(2'(sz), 3'd0, 5'd4, 5'd1), '0, rnd_vec(), g, s);
      // R4: only non-lead bits of 64-bit elements set -> nothing written
      apply(mk(2'b11, 3'd7, 5'd3, 5'd2), 32'hFEFE_FEFE, rnd_vec(), g, s);
      // R4: odd bits only for 16-bit elements -> nothing written
      apply(mk(2'b01, 3'd1, 5'd3, 5'd2), 32'hAAAA_AAAA, rnd_vec(), g, s);
      // R7: source 31 versus 30
      apply(mk(2'b11, 3'd0, 5'd31, 5'd5), '1, rnd_vec(), g, s);
      apply(mk(2'b11, 3'd0, 5'd30, 5'd5), '1, rnd_vec(), g, s);
      // R1: single bit flips in each fixed field
      for (int b = 13; b < 32; b++)
         if (b != 22 && b != 23)
            apply(mk(2'b00, 3'd0, 5'd0, 5'd0) ^ (32'd1 << b), '1, rnd_vec(), g, s);
      // random mix
      for (int it = 0; it < 400; it++) begin
         ov = rnd_vec();
         g  = {$urandom, $urandom};
         s  = {$urandom, $urandom};
         w  = mk(2'($urandom), 3'($urandom), 5'($urandom), 5'($urandom));
         if ($urandom % 8 == 0) w = w ^ (32'd1 << (13 + $urandom % 19));
         apply(w, PW'($urandom), ov, g, s);
      end
      @(negedge clk);
      chk("R2 final idle", VLEN'(res_valid), '0);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #1_000_000;
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule